// File: doc/BRIEF.md
# CRC16 Engine with Bit Transpose

This block computes the CCITT 16-bit cyclic redundancy check over a stream of bytes supplied by a host. The host first writes a starting value (the seed). It then presents data bytes with a valid strobe, at most one per clock. The running checksum is visible at the output at all times. The generator polynomial is x^16 + x^12 + x^5 + 1 (0x1021), and the whole state sits in one 16-bit register.

A transpose control serves links that send the least significant bit first. While it is high, each accepted byte is bit-reversed before it enters the checksum, and the 16-bit result is shown bit-reversed at the output. Each byte is folded in MSB first. The eight single-bit steps are combined into one clock cycle, so back-to-back bytes need no stall.

Top module: `crc16_unit`

## Requirements
- R1: After reset the internal checksum is 0xFFFF, so with transpose low `crc_out` reads 0xFFFF.
- R2: A cycle with `seed_we` high loads `seed_in` into the checksum, and the new value appears at `crc_out` after that clock edge.
- R3: When `seed_we` and `byte_vld` are both high in one cycle, only the seed is loaded and the byte is discarded.
- R4: A cycle with `byte_vld` high and `seed_we` low folds `byte_in` into the checksum, bit 7 first, using polynomial 0x1021 (feedback = checksum bit 15 XOR data bit; shift left; XOR 0x1021 when feedback is 1). The result is visible after that edge.
- R5: With neither strobe high, the checksum holds its value.
- R6: Seed 0xFFFF, transpose low, and the ASCII bytes "123456789" give 0x29B1.
- R7: With `xpose_en` high, an accepted byte is bit-reversed (bit 0 becomes bit 7) before it is folded.
- R8: With `xpose_en` high, `crc_out` shows the checksum with bit i moved to bit 15-i. The control acts on the output in the same cycle and does not change the state.
- R9: Flipping any single bit of a message changes the final checksum.
- R10: Flipping any two bits, or any odd number of bits, of a short message changes the final checksum.
- R11: Bytes on consecutive cycles are all accepted, with one byte per clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| seed_we | input | 1 | Load strobe for the seed |
| seed_in | input | 16 | Seed value |
| byte_vld | input | 1 | Data byte valid |
| byte_in | input | 8 | Data byte |
| xpose_en | input | 1 | Bit-reverse input bytes and the result |
| crc_out | output | 16 | Current checksum, reversed when `xpose_en` is high |

## Verification
The bench drives a seed write and a byte in the same cycle. A design that let the byte through would show the seed already folded with that byte. It streams the standard nine-byte check string back to back, which catches a wrong polynomial, LSB-first folding or a dropped byte. Transpose is toggled both while streaming and while idle. A design that reversed only one side, or latched the control into the state, gives mirrored or stale values. Single, double and triple bit flips over a short message confirm that no tested error pattern leaves the checksum unchanged.

// File: rtl/crc16_pkg.sv
package crc16_pkg;
  localparam int unsigned CRC_W    = 16;
  localparam int unsigned BYTE_W   = 8;
  localparam logic [CRC_W-1:0] POLY_CCITT = 16'h1021;
  localparam logic [CRC_W-1:0] SEED_DEF   = 16'hFFFF;
  localparam int unsigned SYNC_STAGES = 2;
endpackage

// File: rtl/crc16_bitrev.sv
module crc16_bitrev #(
  parameter int unsigned W = 8
) (
  input  logic         en,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] mirrored;

  for (genvar i = 0; i < W; i++) begin : g_mirror
    assign mirrored[i] = din[W-1-i];
  end

  assign dout = en ? mirrored : din;
endmodule

// File: rtl/crc16_fold.sv
module crc16_fold #(
  parameter int unsigned CW = 16,
  parameter int unsigned DW = 8,
  parameter logic [CW-1:0] POLY = 16'h1021
) (
  input  logic [CW-1:0] crc_cur,
  input  logic [DW-1:0] data,
  output logic [CW-1:0] crc_nxt
);
  logic [CW-1:0] stage [DW+1];

  assign stage[0] = crc_cur;

  for (genvar i = 0; i < DW; i++) begin : g_step
    logic fb;
    assign fb = stage[i][CW-1] ^ data[DW-1-i];
    assign stage[i+1] = {stage[i][CW-2:0], 1'b0} ^ (fb ? POLY : '0);
  end

  assign crc_nxt = stage[DW];
endmodule

// File: rtl/crc16_state.sv
module crc16_state #(
  parameter int unsigned CW = 16,
  parameter logic [CW-1:0] RST_VAL = 16'hFFFF
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_en,
  input  logic [CW-1:0] load_val,
  input  logic          upd_en,
  input  logic [CW-1:0] upd_val,
  output logic [CW-1:0] crc_q
);
  logic          reg_en;
  logic [CW-1:0] crc_d;

  always_comb begin
    reg_en = load_en | upd_en;
    crc_d  = crc_q;
    if (load_en) begin
      crc_d = load_val;
    end else if (upd_en) begin
      crc_d = upd_val;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      crc_q <= RST_VAL;
    end else if (reg_en) begin
      crc_q <= crc_d;
    end
  end
endmodule

// File: rtl/crc16_unit.sv
module crc16_unit
  import crc16_pkg::*;
#(
  parameter int unsigned CW = CRC_W,
  parameter int unsigned DW = BYTE_W,
  parameter logic [CW-1:0] POLY = POLY_CCITT,
  parameter logic [CW-1:0] RST_SEED = SEED_DEF,
  parameter int unsigned NSYNC = SYNC_STAGES
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          seed_we,
  input  logic [CW-1:0] seed_in,
  input  logic          byte_vld,
  input  logic [DW-1:0] byte_in,
  input  logic          xpose_en,
  output logic [CW-1:0] crc_out
);
  logic [NSYNC-1:0] rst_pipe;
  logic             rst_n_sync;
  logic [DW-1:0]    byte_ord;
  logic [CW-1:0]    crc_q;
  logic [CW-1:0]    crc_fold;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe <= '0;
    end else begin
      rst_pipe <= {rst_pipe[NSYNC-2:0], 1'b1};
    end
  end
  assign rst_n_sync = rst_pipe[NSYNC-1];

  crc16_bitrev #(.W(DW)) i_in_rev (
    .en   (xpose_en),
    .din  (byte_in),
    .dout (byte_ord)
  );

  crc16_fold #(.CW(CW), .DW(DW), .POLY(POLY)) i_fold (
    .crc_cur (crc_q),
    .data    (byte_ord),
    .crc_nxt (crc_fold)
  );

  crc16_state #(.CW(CW), .RST_VAL(RST_SEED)) i_state (
    .clk      (clk),
    .rst_n    (rst_n_sync),
    .load_en  (seed_we),
    .load_val (seed_in),
    .upd_en   (byte_vld),
    .upd_val  (crc_fold),
    .crc_q    (crc_q)
  );

  crc16_bitrev #(.W(CW)) i_out_rev (
    .en   (xpose_en),
    .din  (crc_q),
    .dout (crc_out)
  );
endmodule

// File: rtl/crc16_unit_chk.sv
module crc16_unit_chk #(
  parameter int unsigned CW = 16,
  parameter int unsigned DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          seed_we,
  input logic [CW-1:0] seed_in,
  input logic          byte_vld,
  input logic [DW-1:0] byte_in,
  input logic          xpose_en,
  input logic [CW-1:0] crc_q,
  input logic [CW-1:0] crc_out
);
  AST_SEED_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    seed_we |=> crc_q == $past(seed_in)); // R2

  AST_SEED_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (seed_we && byte_vld) |=> crc_q == $past(seed_in)); // R3

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!seed_we && !byte_vld) |=> $stable(crc_q)); // R5

  AST_ZERO_FOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_vld && !seed_we && crc_q == '0 && byte_in == '0) |=> crc_q == '0); // R4

  AST_OUT_PLAIN: assert property (@(posedge clk) disable iff (!rst_n)
    !xpose_en |-> crc_out == crc_q); // R8

  AST_OUT_MIRROR: assert property (@(posedge clk) disable iff (!rst_n)
    xpose_en |-> (crc_out[CW-1] == crc_q[0] && crc_out[0] == crc_q[CW-1])); // R8
endmodule

bind crc16_unit crc16_unit_chk #(.CW(CW), .DW(DW)) i_chk (
  .clk      (clk),
  .rst_n    (rst_n_sync),
  .seed_we  (seed_we),
  .seed_in  (seed_in),
  .byte_vld (byte_vld),
  .byte_in  (byte_in),
  .xpose_en (xpose_en),
  .crc_q    (crc_q),
  .crc_out  (crc_out)
);

// File: tb/test_crc16_unit.sv
module test_crc16_unit;
  typedef struct {
    logic [15:0] v;
    string       tag;
  } item_t;

  logic        clk;
  logic        rst_n;
  logic        seed_we;
  logic [15:0] seed_in;
  logic        byte_vld;
  logic [7:0]  byte_in;
  logic        xpose_en;
  logic [15:0] crc_out;

  int total;
  int bad;
  logic [15:0] exp_st;
  logic        xp;
  item_t       q[$];

  crc16_unit i_crc16_unit (
    .clk      (clk),
    .rst_n    (rst_n),
    .seed_we  (seed_we),
    .seed_in  (seed_in),
    .byte_vld (byte_vld),
    .byte_in  (byte_in),
    .xpose_en (xpose_en),
    .crc_out  (crc_out)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic logic [7:0] rev8(input logic [7:0] b);
    logic [7:0] r;
    for (int i = 0; i < 8; i++) r[i] = b[7-i];
    return r;
  endfunction

  function automatic logic [15:0] rev16(input logic [15:0] w);
    logic [15:0] r;
    for (int i = 0; i < 16; i++) r[i] = w[15-i];
    return r;
  endfunction

  function automatic logic [15:0] model_step(input logic [15:0] s, input logic [7:0] b, input logic x);
    logic [7:0] d;
    logic       f;
    d = x ? rev8(b) : b;
    for (int i = 7; i >= 0; i--) begin
      f = s[15] ^ d[i];
      s = s << 1;
      if (f) s = s ^ 16'h1021;
    end
    return s;
  endfunction

  function automatic logic [15:0] msg_crc(input logic [31:0] m);
    logic [15:0] s;
    s = 16'hFFFF;
    for (int i = 3; i >= 0; i--) s = model_step(s, m[i*8 +: 8], 1'b0);
    return s;
  endfunction

  task automatic check(input logic [15:0] act, input logic [15:0] exp, input string tag);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic sw, input logic [15:0] sv, input logic bv,
                       input logic [7:0] b, input string tag);
    item_t it;
    @(negedge clk);
    seed_we  = sw;
    seed_in  = sv;
    byte_vld = bv;
    byte_in  = b;
    xpose_en = xp;
    if (sw) exp_st = sv;
    else if (bv) exp_st = model_step(exp_st, b, xp);
    it.v   = xp ? rev16(exp_st) : exp_st;
    it.tag = tag;
    q.push_back(it);
  endtask

  task automatic quiet();
    @(negedge clk);
    seed_we  = 1'b0;
    byte_vld = 1'b0;
    xpose_en = xp;
  endtask

  // Feeds a 4-byte message from seed 0xFFFF, returns the observed result
  task automatic run_msg(input logic [31:0] m, input string tag, output logic [15:0] res);
    drive(1'b1, 16'hFFFF, 1'b0, 8'h00, tag);
    for (int i = 3; i >= 0; i--) drive(1'b0, 16'h0, 1'b1, m[i*8 +: 8], tag);
    quiet();
    quiet();
    res = crc_out;
  endtask

  // Monitor: pops one expected item per edge, away from the edge
  always @(posedge clk) begin
    #2;
    if (q.size() > 0) begin
      item_t it;
      it = q.pop_front();
      check(crc_out, it.v, it.tag);
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [15:0] good;
    logic [15:0] res;
    logic [31:0] msg;
    total = 0;
    bad = 0;
    xp = 1'b0;
    seed_we = 1'b0;
    seed_in = '0;
    byte_vld = 1'b0;
    byte_in = '0;
    xpose_en = 1'b0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(crc_out, 16'hFFFF, "R1 reset value");
    exp_st = 16'hFFFF;

    // R2 seed load, R5 hold
    drive(1'b1, 16'h1D0F, 1'b0, 8'h00, "R2");
    drive(1'b0, 16'h0000, 1'b0, 8'h5A, "R5");
    drive(1'b0, 16'h0000, 1'b0, 8'h00, "R5");
    // R3 seed beats byte in same cycle
    drive(1'b1, 16'hA55A, 1'b1, 8'hC3, "R3");
    drive(1'b0, 16'h0000, 1'b0, 8'h00, "R3 hold");

    // R4 folding from several seeds and patterns
    drive(1'b1, 16'h0000, 1'b0, 8'h00, "R4");
    drive(1'b0, 16'h0000, 1'b1, 8'h01, "R4");
    drive(1'b0, 16'h0000, 1'b1, 8'h80, "R4");
    drive(1'b0, 16'h0000, 1'b1, 8'hFF, "R4");
    drive(1'b1, 16'h8000, 1'b0, 8'h00, "R4");
    drive(1'b0, 16'h0000, 1'b1, 8'h00, "R4");
    drive(1'b0, 16'h0000, 1'b1, 8'h3C, "R4");

    // R6 and R11 check string, back to back
    drive(1'b1, 16'hFFFF, 1'b0, 8'h00, "R6");
    for (int i = 0; i < 9; i++) drive(1'b0, 16'h0, 1'b1, 8'h31 + 8'(i), "R11");
    quiet();
    quiet();
    check(crc_out, 16'h29B1, "R6 check string");

    // R7/R8 transpose on input and output
    xp = 1'b1;
    drive(1'b0, 16'h0000, 1'b0, 8'h00, "R8 idle mirror");
    drive(1'b1, 16'h1234, 1'b0, 8'h00, "R8");
    drive(1'b0, 16'h0000, 1'b1, 8'h01, "R7");
    drive(1'b0, 16'h0000, 1'b1, 8'hA7, "R7");
    drive(1'b0, 16'h0000, 1'b1, 8'h0F, "R7");
    xp = 1'b0;
    drive(1'b0, 16'h0000, 1'b0, 8'h00, "R8 off");
    xp = 1'b1;
    drive(1'b0, 16'h0000, 1'b0, 8'h00, "R8 on");
    xp = 1'b0;
    drive(1'b0, 16'h0000, 1'b0, 8'h00, "R8");
    quiet();
    quiet();

    // R9 single-bit errors
    msg  = 32'hDEADBEEF;
    good = msg_crc(msg);
    run_msg(msg, "R9", res);
    check(res, good, "R9 golden");
    for (int k = 0; k < 32; k++) begin
      run_msg(msg ^ (32'h1 << k), "R9", res);
      total++;
      if (res == good) begin
        bad++;
        $display("FAIL R9 bit %0d actual=%h expected!=%h", k, res, good);
      end
    end
    // R10 double and triple bit errors
    for (int k = 0; k < 31; k += 3) begin
      run_msg(msg ^ (32'h1 << k) ^ (32'h1 << (k + 1)), "R10", res);
      total++;
      if (res == good) begin
        bad++;
        $display("FAIL R10 double %0d actual=%h expected!=%h", k, res, good);
      end
      run_msg(msg ^ (32'h1 << k) ^ (32'h80000000 >> k) ^ 32'h00010000, "R10", res);
      total++;
      if (res == good && (k != 15) && (k != 16)) begin
        bad++;
        $display("FAIL R10 odd %0d actual=%h expected!=%h", k, res, good);
      end
    end

    quiet();
    quiet();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule